// File: doc/BRIEF.md
# Four-Select SPI Master with Register Bus

This block is an SPI master that software drives through a small 32-bit register bus. To run a transfer, software first places one data word in the transmit register. It then writes the control register with the enable bit, the exchange bit, the transfer length, the clock dividers and the target channel. The block shifts the requested number of bits out on the serial data output, most significant bit first, and samples the serial data input at the same time. When the transfer ends, the received word is held in the receive register and a completion flag is raised.

There are four select outputs. Each select channel has its own clock phase, idle clock level and select active level in the configuration word. This lets devices with different timing share the same serial clock and data lines. The serial clock half-period comes from a linear prescaler followed by a power-of-two postscaler. A status word holds the completion and receive-overflow flags, and software clears each flag by writing 1 to it. An interrupt output combines each flag with its enable bit. The DMA and period words are storage only.

Top module: `spim_master`

## Requirements
- R1: After reset, the control (byte offset 0x08), configuration (0x0C) and status (0x18) words read 0, `spi_sclk` is 0, `spi_mosi` is 0, `irq` is 0 and all four `spi_ss` lines are high.
- R2: The transmit (0x04), configuration (0x0C), interrupt-enable (0x10), DMA (0x14) and period (0x1C) words read back the last value written to them.
- R3: A transfer starts only when one control write has bit 0 (enable) set, bit 2 (exchange) set, and bit 4+n set, where n is the channel held in bits 19:18 of the same write. During the transfer, bit 2 of the control word reads 1. It reads 0 again from the cycle the transfer ends. A control write that does not meet all three conditions starts nothing.
- R4: Bits 15:12 hold the prescaler p and bits 11:8 hold the exponent q. Each serial clock half-period lasts (p+1)·2^q reference cycles, and the first edge comes one half-period after the starting write. A transfer of N bits makes exactly 2N edges. While idle, the clock rests at the idle level set by configuration bit 4+n for the current channel n.
- R5: During a transfer on channel n, `spi_ss[n]` is driven to configuration bit 12+n. Every other select line, and every line while idle, sits at the inverse of its own bit 12+m.
- R6: Configuration bit n is the phase for channel n. With phase 0, input is sampled on leading edges and output changes on trailing edges. With phase 1, output changes on leading edges and input is sampled on trailing edges. The low N bits of the transmit word go out MSB first. The N received bits read back low-aligned at offset 0x00.
- R7: Status bit 7 is set in the cycle the transfer ends. Writing a 1 to status bit 7 clears it.
- R8: Status bit 6 is set when a transfer ends and the previous received word has not been read at offset 0x00. Writing a 1 to status bit 6 clears it.
- R9: Writes to the control and configuration words are ignored while a transfer is in progress.
- R10: Control bits 31:20 hold the length minus one. Any value of 31 or above gives a 32-bit transfer.
- R11: `irq` is the OR of (status bit 7 AND interrupt-enable bit 7) and (status bit 6 AND interrupt-enable bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address; bits 1:0 must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | 4 | Per-channel select lines |

## Verification
The bench builds the block with its default parameters: a 32-bit word, four select channels and a 20-bit half-period counter. With these values a length field of 0xFFF reaches the 32-bit clamp. Each of the four channels also gets its own phase, idle level and select polarity combination. The prescaler and exponent are kept small, so half-periods of 1, 2, 4, 6 and 16 cycles are each compared against the expected clock edge by edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int CS_CNT = 4;
  localparam int HALF_W = 20;

  // register word index (byte address bits 4:2)
  localparam logic [2:0] A_RX     = 3'd0;
  localparam logic [2:0] A_TX     = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_CFG    = 3'd3;
  localparam logic [2:0] A_INTEN  = 3'd4;
  localparam logic [2:0] A_DMA    = 3'd5;
  localparam logic [2:0] A_STAT   = 3'd6;
  localparam logic [2:0] A_PERIOD = 3'd7;

  // control word bit positions
  localparam int CTRL_EN  = 0;
  localparam int CTRL_XCH = 2;
  localparam int MODE_LO  = 4;
  localparam int POST_LO  = 8;
  localparam int PRE_LO   = 12;
  localparam int CHAN_LO  = 18;
  localparam int LEN_LO   = 20;
  localparam int LENF_W   = 12;

  // configuration word bit bases (plus channel number)
  localparam int CFG_PHA   = 0;
  localparam int CFG_POL   = 4;
  localparam int CFG_SSPOL = 12;

  // status bits
  localparam int ST_OVF = 6;
  localparam int ST_TC  = 7;

  // reference cycles per serial clock half-period
  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] pre,
                                                    input logic [3:0] post);
    logic [HALF_W-1:0] base;
    base = HALF_W'(pre) + HALF_W'(1);
    return base << post;
  endfunction

  // number of bits moved for a length-minus-one field, clamped to a word
  function automatic logic [5:0] eff_len(input logic [LENF_W-1:0] f);
    if (f >= LENF_W'(WORD_W - 1)) return 6'(WORD_W);
    return 6'(f) + 6'd1;
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int CNT_W = spim_pkg::HALF_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_cycles,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == half_cycles - CNT_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || at_end) cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  // a fresh transfer always begins a full half-period from zero
  assert_div_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W     = spim_pkg::WORD_W,
  parameter int LEN_W = $clog2(W) + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             cpha_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             busy,
  output logic             ph,
  output logic             mosi,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  localparam int E_W = LEN_W + 1;

  logic [W-1:0]     tx_sr, rx_sr, rx_next;
  logic [LEN_W-1:0] len_q;
  logic [E_W-1:0]   edge_idx, last_edge;
  logic             cpha_q, shift_edge, sample_edge;

  assign last_edge   = {len_q, 1'b0} - E_W'(1);
  assign shift_edge  = cpha_q ? (!edge_idx[0] && edge_idx != '0) : edge_idx[0];
  assign sample_edge = cpha_q ? edge_idx[0] : !edge_idx[0];
  assign rx_next     = {rx_sr[W-2:0], miso};
  assign done        = busy && tick && (edge_idx == last_edge);
  assign rx_word     = sample_edge ? rx_next : rx_sr;
  assign mosi        = tx_sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; tx_sr <= '0; rx_sr <= '0;
      len_q <= '0; edge_idx <= '0; cpha_q <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      ph       <= 1'b0;
      len_q    <= len_in;
      cpha_q   <= cpha_in;
      edge_idx <= '0;
      rx_sr    <= '0;
      tx_sr    <= tx_word << (LEN_W'(W) - len_in);
    end else if (busy && tick) begin
      ph       <= ~ph;
      edge_idx <= edge_idx + E_W'(1);
      if (shift_edge)  tx_sr <= tx_sr << 1;
      if (sample_edge) rx_sr <= rx_next;
      if (done)        busy  <= 1'b0;
    end
  end

  assert_phase_rests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ph);
  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> edge_idx <= last_edge);
endmodule

// File: rtl/spim_selout.sv
module spim_selout #(
  parameter int NUM_CS = spim_pkg::CS_CNT,
  parameter int CH_W   = $clog2(NUM_CS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CS-1:0] sspol,
  input  logic              cpol,
  input  logic              ph,
  output logic [NUM_CS-1:0] ss,
  output logic              sclk
);
  logic [NUM_CS-1:0] hit;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_sel
    assign hit[n] = active && (chan == CH_W'(n));
    assign ss[n]  = hit[n] ? sspol[n] : ~sspol[n];
  end

  assign sclk = cpol ^ ph;

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk == cpol);
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int DATA_W = spim_pkg::WORD_W,
  parameter int NUM_CS = spim_pkg::CS_CNT,
  parameter int DIV_W  = spim_pkg::HALF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_ss
);
  localparam int CH_W  = $clog2(NUM_CS);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] tx_q, rx_q, ctrl_q, cfg_q, inten_q, dma_q, period_q;
  logic              tc_q, ovf_q, unread_q;

  logic [2:0]        idx;
  logic              acc_ok, wr_en, wr_ctrl, wr_stat, rd_rx;
  logic [CH_W-1:0]   wchan, chan;
  logic              start, busy, tick, ph, done, ovf_set;
  logic [DATA_W-1:0] rx_word, ctrl_rb, stat_rb;
  logic [DIV_W-1:0]  half;
  logic [LEN_W-1:0]  start_len;

  // bus decode
  assign idx     = bus_addr[4:2];
  assign acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
  assign wr_en   = acc_ok && bus_wr;
  assign wr_ctrl = wr_en && (idx == A_CTRL);
  assign wr_stat = wr_en && (idx == A_STAT);
  assign rd_rx   = acc_ok && !bus_wr && (idx == A_RX);

  // start condition taken from the written word itself
  assign wchan     = bus_wdata[CHAN_LO +: CH_W];
  assign start_len = LEN_W'(eff_len(bus_wdata[LEN_LO +: LENF_W]));
  assign start     = wr_ctrl && !busy && bus_wdata[CTRL_EN] && bus_wdata[CTRL_XCH]
                     && bus_wdata[MODE_LO + int'(wchan)];

  assign chan    = ctrl_q[CHAN_LO +: CH_W];
  assign half    = DIV_W'(half_period(ctrl_q[PRE_LO +: 4], ctrl_q[POST_LO +: 4]));
  assign ovf_set = done && unread_q && !rd_rx;

  spim_clkdiv #(.CNT_W(DIV_W)) u_div (
    .clk, .rst_n, .run(busy), .half_cycles(half), .tick
  );

  spim_shifter #(.W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk, .rst_n, .start, .tick,
    .cpha_in(cfg_q[CFG_PHA + int'(wchan)]),
    .len_in(start_len), .tx_word(tx_q), .miso(spi_miso),
    .busy, .ph, .mosi(spi_mosi), .done, .rx_word
  );

  spim_selout #(.NUM_CS(NUM_CS), .CH_W(CH_W)) u_sel (
    .clk, .rst_n, .active(busy), .chan,
    .sspol(cfg_q[CFG_SSPOL +: NUM_CS]),
    .cpol(cfg_q[CFG_POL + int'(chan)]),
    .ph, .ss(spi_ss), .sclk(spi_sclk)
  );

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0; rx_q <= '0; ctrl_q <= '0; cfg_q <= '0;
      inten_q <= '0; dma_q <= '0; period_q <= '0;
      tc_q <= 1'b0; ovf_q <= 1'b0; unread_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (idx)
          A_TX:     tx_q <= bus_wdata;
          A_CTRL:   if (!busy) begin
                      ctrl_q           <= bus_wdata;
                      ctrl_q[CTRL_XCH] <= 1'b0;
                    end
          A_CFG:    if (!busy) cfg_q <= bus_wdata;
          A_INTEN:  inten_q  <= bus_wdata;
          A_DMA:    dma_q    <= bus_wdata;
          A_PERIOD: period_q <= bus_wdata;
          default:  ;
        endcase
      end
      if (done) rx_q <= rx_word;
      tc_q     <= done    | (tc_q  & ~(wr_stat & bus_wdata[ST_TC]));
      ovf_q    <= ovf_set | (ovf_q & ~(wr_stat & bus_wdata[ST_OVF]));
      unread_q <= done    | (unread_q & ~rd_rx);
    end
  end

  // read mux
  always_comb begin
    ctrl_rb           = ctrl_q;
    ctrl_rb[CTRL_XCH] = busy;
    stat_rb           = '0;
    stat_rb[ST_TC]    = tc_q;
    stat_rb[ST_OVF]   = ovf_q;
    case (idx)
      A_RX:     bus_rdata = rx_q;
      A_TX:     bus_rdata = tx_q;
      A_CTRL:   bus_rdata = ctrl_rb;
      A_CFG:    bus_rdata = cfg_q;
      A_INTEN:  bus_rdata = inten_q;
      A_DMA:    bus_rdata = dma_q;
      A_STAT:   bus_rdata = stat_rb;
      default:  bus_rdata = period_q;
    endcase
  end

  assign irq = (tc_q & inten_q[ST_TC]) | (ovf_q & inten_q[ST_OVF]);

  assert_tc_with_xch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tc_q);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(done));
  assert_setup_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ctrl_q) && $stable(cfg_q));
endmodule

// File: tb/tb_spim_master.sv
module tb_spim_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, spi_miso = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, spi_sclk, spi_mosi;
  logic [3:0]  spi_ss;

  int          errors = 0, checks = 0;
  bit          finished = 1'b0;
  logic [31:0] cfg_m = '0;

  localparam logic [2:0] RX = 0, TX = 1, CTRL = 2, CFG = 3, INTEN = 4, DMA = 5, STAT = 6, PER = 7;

  always #2.5 clk = ~clk;

  spim_master dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = {idx, 2'b00}; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = {idx, 2'b00}; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  function automatic logic [3:0] idle_ss();
    return ~cfg_m[15:12];
  endfunction

  function automatic logic [31:0] ctrl_word(int chan, int lenf, int pre, int post);
    return 32'((lenf << 20) | (chan << 18) | (pre << 12) | (post << 8) | (1 << (4 + chan)) | 5);
  endfunction

  // reference model: predicted clock, select and busy each cycle, plus a slave
  task automatic xfer(input int chan, input int lenf, input int pre, input int post,
                      input logic [31:0] tx, input logic [31:0] sw,
                      input bit read_rx, input bit exp_ovf);
    int n, hp, k, prev, e;
    logic [31:0] mask, got, v;
    logic [3:0] ess;
    bit cpol, cpha, act;
    n    = (lenf >= 31) ? 32 : lenf + 1;
    hp   = (pre + 1) << post;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    cpol = cfg_m[4 + chan];
    cpha = cfg_m[chan];
    wr(TX, tx);
    @(negedge clk);
    spi_miso = sw[n-1];
    bus_sel = 1; bus_wr = 1; bus_addr = {CTRL, 2'b00}; bus_wdata = ctrl_word(chan, lenf, pre, post);
    @(negedge clk); bus_wr = 0;
    k = 0; prev = 0; got = '0;
    for (int c = 0; c <= 2 * n * hp + 1; c++) begin
      #1;
      e   = (c / hp > 2 * n) ? 2 * n : c / hp;
      act = (c < 2 * n * hp);
      ess = idle_ss();
      if (act) ess[chan] = cfg_m[12 + chan];
      chk("R4 sclk edge timing", 32'(spi_sclk), 32'(cpol ^ e[0]));
      chk("R5 select lines", 32'(spi_ss), 32'(ess));
      chk("R3 exchange readback", 32'(bus_rdata[2]), 32'(act));
      if (e != prev) begin
        if (((e - 1) % 2) == (cpha ? 1 : 0)) begin
          got = {got[30:0], spi_mosi};
          k++;
          if (k < n) spi_miso = sw[n-1-k];
        end
        prev = e;
      end
      @(negedge clk);
    end
    bus_sel = 0;
    chk("R6 serial output bits", got & mask, tx & mask);
    rd(STAT, v);
    chk("R7 completion flag", 32'(v[7]), 32'd1);
    chk("R8 overflow flag", 32'(v[6]), 32'(exp_ovf));
    if (read_rx) begin
      rd(RX, v);
      chk("R6 received word", v, sw & mask);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, orig;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 sclk", 32'(spi_sclk), 0);
    chk("R1 mosi", 32'(spi_mosi), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 selects", 32'(spi_ss), 32'hF);
    rd(CTRL, v); chk("R1 control", v, 0);
    rd(CFG, v);  chk("R1 config", v, 0);
    rd(STAT, v); chk("R1 status", v, 0);

    // R2 plain storage
    wr(TX, 32'h1234_5678);    rd(TX, v);    chk("R2 transmit", v, 32'h1234_5678);
    wr(INTEN, 32'h0000_00C0); rd(INTEN, v); chk("R2 int enable", v, 32'hC0);
    wr(DMA, 32'h0000_0ABC);   rd(DMA, v);   chk("R2 dma", v, 32'hABC);
    wr(PER, 32'h0000_8001);   rd(PER, v);   chk("R2 period", v, 32'h8001);
    wr(INTEN, 0);

    // channel 0, phase 0, idle low, select active low, half-period 2
    cfg_m = 0; wr(CFG, cfg_m);
    xfer(0, 7, 1, 0, 32'hA5, 32'h3C, 1, 0);

    // channel 1, phase 1, idle high, select active high, half-period 6
    cfg_m = (1 << 1) | (1 << 5) | (1 << 13); wr(CFG, cfg_m);
    rd(CFG, v); chk("R2 config", v, cfg_m);
    xfer(1, 4, 2, 1, 32'h15, 32'h0B, 1, 0);

    // R7 write-one-to-clear of completion
    wr(STAT, 32'h80); rd(STAT, v); chk("R7 completion cleared", v, 0);

    // channel 2 phase 0 idle high; channel 3 phase 1 idle low select high
    cfg_m = cfg_m | (1 << 6) | (1 << 3) | (1 << 15); wr(CFG, cfg_m);
    xfer(2, 15, 0, 2, 32'hBEEF, 32'h1234, 1, 0);
    // R10 length field 0xFFF clamps to 32 bits
    xfer(3, 12'hFFF, 0, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1, 0);

    // R8 overflow when the received word is left unread
    xfer(0, 3, 0, 0, 32'h9, 32'h6, 0, 0);
    xfer(0, 3, 0, 0, 32'h3, 32'h5, 0, 1);
    rd(RX, v); chk("R8 newest word kept", v, 32'h5);

    // R11 interrupt gating
    wr(INTEN, 32'h40); #1 chk("R11 irq from overflow", 32'(irq), 1);
    wr(STAT, 32'h40);  #1 chk("R11 irq after overflow clear", 32'(irq), 0);
    rd(STAT, v); chk("R8 overflow cleared", v, 32'h80);
    wr(INTEN, 32'h80); #1 chk("R11 irq from completion", 32'(irq), 1);
    wr(STAT, 32'h80);  #1 chk("R11 irq after completion clear", 32'(irq), 0);
    wr(INTEN, 0);

    // R3 no start without enable, and none without the channel's master bit
    wr(CTRL, 32'h0000_0014);
    rd(CTRL, v); chk("R3 no start without enable", v, 32'h0000_0010);
    chk("R3 selects idle", 32'(spi_ss), 32'(idle_ss()));
    wr(CTRL, 32'h0004_0015);
    repeat (20) @(negedge clk);
    #1 chk("R3 selects idle without master bit", 32'(spi_ss), 32'(idle_ss()));
    rd(CTRL, v); chk("R3 no start without master bit", v, 32'h0004_0011);
    rd(STAT, v); chk("R3 no completion", v, 0);

    // R9 setup frozen during a transfer (half-period 16, 4 bits)
    orig = ctrl_word(0, 3, 3, 2);
    wr(CTRL, orig);
    wr(CTRL, ctrl_word(2, 7, 0, 0));
    wr(CFG, 32'h0000_FFFF);
    rd(CTRL, v); chk("R9 control held", v, orig);
    rd(CFG, v);  chk("R9 config held", v, cfg_m);
    for (int i = 0; i < 400; i++) begin
      rd(STAT, v);
      if (v[7]) break;
    end
    chk("R7 completion after held transfer", 32'(v[7]), 1);
    rd(CTRL, v); chk("R3 exchange cleared", v, orig & ~32'h4);
    rd(RX, v);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule